// File: doc/BRIEF.md
# Request/Grant Bus Handover Unit

This unit lends the local bus to other bus masters over single-wire pulse channels. Each wire is active low and carries traffic both ways, so it is modelled here as three signals: an input, an output, and an output enable. One handover is a three-pulse exchange. The other master sends a request pulse. This unit answers with a grant pulse. The master later sends a release pulse.

The unit follows the phase of the bus sequencer's current clock: idle, T1, T2, T3, wait or T4. At T4 it also looks at three qualifiers: a locked instruction is running, the cycle is the first half of a split odd-address word, or the cycle is the first interrupt acknowledge. From these it decides the clock in which it may give the bus away.

While another master owns the bus, the unit floats the bus and stalls the sequencer so that no new cycle begins. It takes the bus back on the clock after the release pulse. It then keeps one dead clock before any further exchange can begin. Channel 0 has priority over channel 1.

Top module: `rg_bus_handover`

## Requirements
- R1: During reset and on the first clock after it, every channel output is high with its enable low, and both the float flag and the stall flag are low.
- R2: A grant is a single-clock low on the channel output, with that channel's enable high. It occurs only in a clock whose phase code is T4 (5) or idle (0). At most one channel is granted in any clock.
- R3: The stall flag is high in the grant clock. From the next clock, float and stall stay high until the owner releases the bus. No grant is driven during hold.
- R4: A low on the owning channel's input during hold ends the hold. Float and stall are low on the following clock. A low on any other channel does not end the hold.
- R5: The clock after a release is a dead clock. No grant is issued in it, and a request pulse seen in it is discarded and never granted.
- R6: At T4, the bus is not released if any of lock, split-low or first-acknowledge is high. The request stays pending and is granted at the next T4 where all three are low.
- R7: A request first seen in an idle, T1 or T2 clock (codes 0, 1, 2) can be granted at the T4 of the same cycle. A request first seen in T3, wait or T4 (codes 3, 4, 5) is held pending and granted at the T4 of the following cycle.
- R8: A request seen in an idle clock is granted on the next clock if that clock is also idle.
- R9: When both channels request in the same clock, channel 0 (input bit 0) is granted first. The channel 1 request stays pending and is granted at the first eligible clock after channel 0's exchange and its dead clock.
- R10: A request pulse on one channel while another channel holds the bus is ignored and never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Phase of the current clock: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4 |
| lock_i | input | 1 | A locked instruction is running |
| split_lo_i | input | 1 | Current cycle is the first half of a split odd-address word |
| ack_first_i | input | 1 | Current cycle is the first interrupt acknowledge |
| rq_n_i | input | NCH | Sensed level of each request/grant wire, active low |
| rq_n_o | output | NCH | Value driven onto each wire, active low |
| rq_oe_o | output | NCH | Output enable for each wire |
| bus_float_o | output | 1 | Bus and control lines are floated (hold) |
| seq_stall_o | output | 1 | Sequencer must not start a new bus cycle |

## Verification
The bench builds the unit with its default of two channels. This is the smallest setup in which priority, and the ignoring of the other channel during hold, can be observed.

With that setup, it sweeps every arrival phase of a request across a cycle that contains a wait state, against all eight combinations of the three T4 qualifiers. Each case runs through the full grant, hold, release and dead-clock sequence. Directed runs cover idle-bus grants, simultaneous requests, and pulses on the second wire during hold and during the dead clock.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        XS_OPEN = 2'd0,
        XS_HOLD = 2'd1,
        XS_DEAD = 2'd2
    } xchg_e;

    typedef struct packed {
        logic lock;
        logic split_lo;
        logic ack_first;
    } cyc_flags_t;

    // A request seen in one of these phases is in time for the current cycle's T4.
    function automatic logic is_early_phase(input logic [2:0] ph);
        return (ph == PH_IDLE) || (ph == PH_T1) || (ph == PH_T2);
    endfunction

    // The T4 release point is usable only when no qualifier blocks it.
    function automatic logic t4_release_ok(input cyc_flags_t f);
        return !(f.lock || f.split_lo || f.ack_first);
    endfunction

endpackage

// File: rtl/rg_req_tracker.sv
module rg_req_tracker
    import rg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] rq_n_i,
    input  logic [NCH-1:0] cap_en,
    input  logic [NCH-1:0] gnt,
    input  logic [2:0]     phase,
    output logic [NCH-1:0] pend,
    output logic [NCH-1:0] armed
);

    logic early;
    assign early = is_early_phase(phase);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic cap;
        assign cap = cap_en[c] & ~rq_n_i[c];

        always_ff @(posedge clk) begin
            if (rst) begin
                pend[c]  <= 1'b0;
                armed[c] <= 1'b0;
            end else begin
                pend[c]  <= ~gnt[c] & (pend[c] | cap);
                armed[c] <= ~gnt[c] & (pend[c] | cap) & (armed[c] | early);
            end
        end

        AST_ARMED_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
            armed[c] |-> pend[c]) else $error("armed without pending"); // R7
    end

endmodule

// File: rtl/rg_grant_pick.sv
module rg_grant_pick
    import rg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pend,
    input  logic [NCH-1:0] armed,
    input  logic [2:0]     phase,
    input  cyc_flags_t     flags,
    input  logic           open,
    output logic [NCH-1:0] gnt
);

    logic [NCH-1:0] elig;
    logic           at_idle;
    logic           at_t4;

    assign at_idle = (phase == PH_IDLE);
    assign at_t4   = (phase == PH_T4) && t4_release_ok(flags);

    for (genvar c = 0; c < NCH; c++) begin : g_elig
        assign elig[c] = open & pend[c] & (at_idle | (at_t4 & armed[c]));
    end

    // Lowest index wins.
    always_comb begin
        gnt = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig[c]) gnt = NCH'(1) << c;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)) else $error("more than one grant"); // R2

    AST_GNT_PHASE: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |-> (phase == PH_T4 || phase == PH_IDLE)) else $error("grant off T4/idle"); // R2

    AST_T4_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T4 && (flags.lock || flags.split_lo || flags.ack_first)) |-> (gnt == '0))
        else $error("grant despite blocking qualifier"); // R6

endmodule

// File: rtl/rg_xchg_fsm.sv
module rg_xchg_fsm
    import rg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] rq_n_i,
    input  logic [NCH-1:0] gnt,
    output logic [NCH-1:0] cap_en,
    output logic           open,
    output logic           bus_float,
    output logic           stall
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    xchg_e         state;
    logic [IW-1:0] owner;
    logic [IW-1:0] gnt_idx;

    always_comb begin
        gnt_idx = '0;
        for (int c = 0; c < NCH; c++) begin
            if (gnt[c]) gnt_idx = IW'(c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= XS_OPEN;
            owner <= '0;
        end else begin
            case (state)
                XS_OPEN: if (|gnt) begin
                    state <= XS_HOLD;
                    owner <= gnt_idx;
                end
                XS_HOLD: if (!rq_n_i[owner]) state <= XS_DEAD;
                XS_DEAD: state <= XS_OPEN;
                default: state <= XS_OPEN;
            endcase
        end
    end

    assign open      = (state == XS_OPEN);
    assign bus_float = (state == XS_HOLD);
    assign stall     = bus_float | (|gnt);

    for (genvar c = 0; c < NCH; c++) begin : g_cap
        assign cap_en[c] = open & ~gnt[c];
    end

    AST_GNT_THEN_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (|gnt) |=> bus_float) else $error("no hold after grant"); // R3

    AST_HOLD_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        bus_float |-> (gnt == '0)) else $error("grant during hold"); // R3

    AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_float) |-> (gnt == '0 && !stall)) else $error("activity in dead clock"); // R5

    AST_HOLD_ENDS_ON_OWNER: assert property (@(posedge clk) disable iff (rst)
        (bus_float && rq_n_i[owner]) |=> bus_float) else $error("hold ended without release"); // R4

endmodule

// File: rtl/rg_bus_handover.sv
module rg_bus_handover
    import rg_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     phase_i,
    input  logic           lock_i,
    input  logic           split_lo_i,
    input  logic           ack_first_i,
    input  logic [NCH-1:0] rq_n_i,
    output logic [NCH-1:0] rq_n_o,
    output logic [NCH-1:0] rq_oe_o,
    output logic           bus_float_o,
    output logic           seq_stall_o
);

    cyc_flags_t     flags;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] armed;
    logic [NCH-1:0] gnt;
    logic [NCH-1:0] cap_en;
    logic           open;

    assign flags = '{lock: lock_i, split_lo: split_lo_i, ack_first: ack_first_i};

    rg_req_tracker #(.NCH(NCH)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .rq_n_i (rq_n_i),
        .cap_en (cap_en),
        .gnt    (gnt),
        .phase  (phase_i),
        .pend   (pend),
        .armed  (armed)
    );

    rg_grant_pick #(.NCH(NCH)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .armed (armed),
        .phase (phase_i),
        .flags (flags),
        .open  (open),
        .gnt   (gnt)
    );

    rg_xchg_fsm #(.NCH(NCH)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rq_n_i    (rq_n_i),
        .gnt       (gnt),
        .cap_en    (cap_en),
        .open      (open),
        .bus_float (bus_float_o),
        .stall     (seq_stall_o)
    );

    assign rq_oe_o = gnt;
    assign rq_n_o  = ~gnt;

    AST_GNT_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (|rq_oe_o) |=> (rq_oe_o == '0)) else $error("grant wider than one clock"); // R2

endmodule

// File: tb/rg_bus_handover_tb_top.sv
module rg_bus_handover_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NCH        = 2;
    localparam int  WDOG_CYC   = 100000;

    localparam logic [2:0] P_IDLE = 3'd0;
    localparam logic [2:0] P_T1   = 3'd1;
    localparam logic [2:0] P_T2   = 3'd2;
    localparam logic [2:0] P_T3   = 3'd3;
    localparam logic [2:0] P_TW   = 3'd4;
    localparam logic [2:0] P_T4   = 3'd5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     phase_i = P_IDLE;
    logic           lock_i = 1'b0;
    logic           split_lo_i = 1'b0;
    logic           ack_first_i = 1'b0;
    logic [NCH-1:0] rq_n_i = '1;
    logic [NCH-1:0] rq_n_o;
    logic [NCH-1:0] rq_oe_o;
    logic           bus_float_o;
    logic           seq_stall_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rg_bus_handover #(.NCH(NCH)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase_i),
        .lock_i      (lock_i),
        .split_lo_i  (split_lo_i),
        .ack_first_i (ack_first_i),
        .rq_n_i      (rq_n_i),
        .rq_n_o      (rq_n_o),
        .rq_oe_o     (rq_oe_o),
        .bus_float_o (bus_float_o),
        .seq_stall_o (seq_stall_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Apply inputs for one clock; outputs are observed before the next rising edge.
    task automatic step(input logic [2:0] ph, input logic [2:0] fl, input logic [NCH-1:0] rqn);
        @(negedge clk);
        phase_i = ph;
        {lock_i, split_lo_i, ack_first_i} = fl;
        rq_n_i = rqn;
        #2;
    endtask

    task automatic chk_grant(input logic [NCH-1:0] exp, input string req);
        chk(rq_oe_o == exp && rq_n_o == ~exp, req, int'(rq_oe_o), int'(exp));
    endtask

    // Hold, release by owner, dead clock with a stray pulse on other, then quiet.
    task automatic hold_release(input int owner, input string req_tag);
        logic [NCH-1:0] rel;
        logic [NCH-1:0] stray;
        rel   = ~(NCH'(1) << owner);
        stray = ~(NCH'(1) << (1 - owner));
        step(P_IDLE, 3'b000, '1);
        chk(bus_float_o && seq_stall_o, {"R3 hold ", req_tag}, int'({bus_float_o, seq_stall_o}), 3);
        chk_grant('0, {"R2 one-clock grant ", req_tag});
        step(P_IDLE, 3'b000, rel);
        chk(bus_float_o, {"R3 hold kept ", req_tag}, int'(bus_float_o), 1);
        step(P_IDLE, 3'b000, stray);
        chk(!bus_float_o && !seq_stall_o, {"R4 reclaim ", req_tag}, int'({bus_float_o, seq_stall_o}), 0);
        chk_grant('0, {"R5 dead clock ", req_tag});
        for (int k = 0; k < 3; k++) begin
            step(P_IDLE, 3'b000, '1);
            chk_grant('0, {"R5 dead pulse dropped ", req_tag});
        end
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [2:0] cyc_ph [5];
        cyc_ph[0] = P_T1; cyc_ph[1] = P_T2; cyc_ph[2] = P_T3; cyc_ph[3] = P_TW; cyc_ph[4] = P_T4;

        // R1 reset state
        rst = 1'b1;
        repeat (3) begin
            step(P_IDLE, 3'b000, '1);
            chk(rq_oe_o == '0 && rq_n_o == '1 && !bus_float_o && !seq_stall_o,
                "R1 reset", int'({rq_oe_o, bus_float_o, seq_stall_o}), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        step(P_IDLE, 3'b000, '1);
        chk(rq_oe_o == '0 && !bus_float_o && !seq_stall_o, "R1 after reset",
            int'({rq_oe_o, bus_float_o, seq_stall_o}), 0);

        // Sweep: arrival phase x T4 qualifiers (R6, R7)
        for (int arr = 0; arr < 5; arr++) begin
            for (int f = 0; f < 8; f++) begin
                bit exp1;
                bit stray;
                exp1  = (arr <= 1) && (f == 0);
                stray = 1'b0;
                step(P_IDLE, 3'b000, '1);
                chk_grant('0, "R2 no spontaneous grant");
                for (int i = 0; i < 5; i++) begin
                    step(cyc_ph[i], (i == 4) ? 3'(f) : 3'b000, (i == arr) ? 2'b10 : 2'b11);
                    if (i < 4 && rq_oe_o != '0) stray = 1'b1;
                end
                chk(!stray, "R2 grant outside T4", int'(stray), 0);
                chk_grant(exp1 ? 2'b01 : 2'b00, (arr <= 1) ? "R6 T4 qualifiers" : "R7 late request");
                chk(seq_stall_o == exp1, "R3 stall in grant clock", int'(seq_stall_o), int'(exp1));
                if (!exp1) begin
                    for (int i = 0; i < 5; i++) begin
                        step(cyc_ph[i], 3'b000, '1);
                        if (i < 4) chk_grant('0, "R7 pending waits for T4");
                    end
                    chk_grant(2'b01, (arr <= 1) ? "R6 pending granted" : "R7 next cycle T4");
                end
                hold_release(0, "sweep");
            end
        end

        // R8 idle bus: request then next idle clock
        step(P_IDLE, 3'b000, 2'b01);
        chk_grant('0, "R8 not in request clock");
        step(P_IDLE, 3'b000, '1);
        chk_grant(2'b10, "R8 idle grant next clock");
        hold_release(1, "R8");

        // R9 simultaneous requests: channel 0 first
        step(P_IDLE, 3'b000, 2'b00);
        step(P_IDLE, 3'b000, '1);
        chk_grant(2'b01, "R9 channel 0 first");
        step(P_IDLE, 3'b000, '1);
        chk(bus_float_o, "R9 hold", int'(bus_float_o), 1);
        step(P_IDLE, 3'b000, 2'b10);
        step(P_IDLE, 3'b000, '1);
        chk_grant('0, "R9 dead clock before channel 1");
        step(P_IDLE, 3'b000, '1);
        chk_grant(2'b10, "R9 channel 1 after dead clock");
        hold_release(1, "R9");

        // R10 other channel pulse during hold: ignored, does not end hold
        step(P_IDLE, 3'b000, 2'b10);
        step(P_IDLE, 3'b000, '1);
        chk_grant(2'b01, "R10 setup grant");
        step(P_IDLE, 3'b000, 2'b01);
        step(P_IDLE, 3'b000, '1);
        chk(bus_float_o, "R4 other channel does not release", int'(bus_float_o), 1);
        step(P_IDLE, 3'b000, 2'b10);
        step(P_IDLE, 3'b000, '1);
        chk(!bus_float_o, "R4 owner release", int'(bus_float_o), 0);
        for (int k = 0; k < 6; k++) begin
            step(P_IDLE, 3'b000, '1);
            chk_grant('0, "R10 ignored pulse not granted");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule